// File: doc/BRIEF.md
# Packed Calendar Counter with BCD Year

This block keeps wall-clock date and time directly in calendar form. A 32-bit time word packs seconds, minutes, hour, weekday, day of month and month. A separate 16-bit word holds the year as four BCD digits. Each cycle in which the one-per-second `tick` enable is high, the counter advances by one second. It carries through minutes, hours and days, and the end of each month depends on its length and on the Gregorian leap rule. The year carries decimally through all four digits.

Software, or a bus bridge outside this block, sets the clock in two steps. It first writes the year word, which is only held in a staging register. It then writes the time word, and that write commits both words together. An alarm output compares both live words against match inputs.

Top module: `cal_word_counter`

## Requirements
- R1: After reset the time word reads 0x021E0000 and the year word reads 0x2000. This is Saturday 2000-01-01 at 00:00:00, with weekday 7 and day and month both 1.
- R2: Time word fields are seconds [5:0], minutes [11:6], hour [16:12], weekday [19:17], day of month [24:20] and month [29:25]. Bits [31:30] read as zero.
- R3: On a tick, seconds advance by one. Seconds at 59 return to 0 and advance minutes, minutes at 59 return to 0 and advance the hour, and hour 23 returns to 0 and starts a new day.
- R4: With `tick` low and no load, neither word changes.
- R5: At a new day, the day of month returns to 1 if it has reached the month's length, and the month advances. Months 4, 6, 9 and 11 have 30 days, February has 28 or 29, and the rest have 31. Month 12 returns to 1 and advances the year.
- R6: February has 29 days when the year is divisible by 4, except century years not divisible by 400. Year 0000 counts as a leap year.
- R7: Weekday (1 = Sunday through 7 = Saturday) advances at every new day and wraps from 7 to 1.
- R8: The year word is BCD, with low two digits in [7:0] and century digits in [15:8]. It increments with decimal carry and wraps from 9999 to 0000.
- R9: A year write only stages the value, so the year output is unchanged. A time write loads the time word and the staged year together, with bits [31:30] of the written value dropped.
- R10: A time write in the same cycle as a tick takes priority, and the loaded values appear unmodified.
- R11: `alarm` is high exactly while the time word equals `match_time` and the year word equals `match_year`. A mismatch in either word holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance enable |
| year_wr | input | 1 | Stage `year_wdata` |
| year_wdata | input | 16 | BCD year to stage |
| time_wr | input | 1 | Commit `time_wdata` and the staged year |
| time_wdata | input | 32 | Packed time word to load |
| match_time | input | 32 | Alarm compare value for the time word |
| match_year | input | 16 | Alarm compare value for the year word |
| time_word | output | 32 | Live packed time word |
| year_word | output | 16 | Live BCD year word |
| alarm | output | 1 | Both words equal their match values |

## Verification
The bench builds the block with its default reset parameters, which start it on Saturday 2000-01-01.

It ticks continuously through a full leap day of 86400 seconds, so every second, minute and hour rollover is compared against an arithmetic model. It also loads the last second of every month for nine years: 2000, 1900, 2100, 2400, 2023, 2024, 1999, 9999 and 0000. This brings all month lengths, every branch of the leap rule, the century carry and the 9999 wrap within reach. It cycles the weekday through all seven values along the way.

// File: rtl/cal_word_counter.sv
module cal_word_counter #(
  parameter logic [31:0] RST_TIME = 32'h021E_0000,
  parameter logic [15:0] RST_YEAR = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        year_wr,
  input  logic [15:0] year_wdata,
  input  logic        time_wr,
  input  logic [31:0] time_wdata,
  input  logic [31:0] match_time,
  input  logic [15:0] match_year,
  output logic [31:0] time_word,
  output logic [15:0] year_word,
  output logic        alarm
);
  localparam int DIGITS = 4;

  logic [31:0] tq;
  logic [15:0] yq, ystage;

  wire [5:0] sec = tq[5:0];
  wire [5:0] mnt = tq[11:6];
  wire [4:0] hr  = tq[16:12];
  wire [2:0] wd  = tq[19:17];
  wire [4:0] md  = tq[24:20];
  wire [4:0] mo  = tq[29:25];

  wire [6:0] yr_lo = 7'(yq[7:4] * 4'd10) + 7'(yq[3:0]);
  wire [6:0] yr_hi = 7'(yq[15:12] * 4'd10) + 7'(yq[11:8]);
  wire leap = (yr_lo != 7'd0) ? (yr_lo[1:0] == 2'b00) : (yr_hi[1:0] == 2'b00);

  logic [4:0] mlen;
  always_comb begin
    case (mo)
      5'd2: mlen = leap ? 5'd29 : 5'd28;
      5'd4, 5'd6, 5'd9, 5'd11: mlen = 5'd30;
      default: mlen = 5'd31;
    endcase
  end

  wire sec_end = sec >= 6'd59;
  wire min_end = mnt >= 6'd59;
  wire hr_end  = hr >= 5'd23;
  wire day_end = md >= mlen;
  wire mon_end = mo >= 5'd12;

  wire c_min = sec_end;
  wire c_hr  = c_min & min_end;
  wire c_day = c_hr & hr_end;
  wire c_mon = c_day & day_end;
  wire c_yr  = c_mon & mon_end;

  wire [5:0] n_sec = sec_end ? 6'd0 : sec + 6'd1;
  wire [5:0] n_min = c_min ? (min_end ? 6'd0 : mnt + 6'd1) : mnt;
  wire [4:0] n_hr  = c_hr ? (hr_end ? 5'd0 : hr + 5'd1) : hr;
  wire [2:0] n_wd  = c_day ? ((wd >= 3'd7) ? 3'd1 : wd + 3'd1) : wd;
  wire [4:0] n_md  = c_day ? (day_end ? 5'd1 : md + 5'd1) : md;
  wire [4:0] n_mo  = c_mon ? (mon_end ? 5'd1 : mo + 5'd1) : mo;

  logic [DIGITS:0] dcarry;
  logic [15:0]     n_yr;
  assign dcarry[0] = c_yr;
  for (genvar i = 0; i < DIGITS; i++) begin : g_bcd
    wire [3:0] d = yq[4*i +: 4];
    wire       top = d >= 4'd9;
    assign n_yr[4*i +: 4] = dcarry[i] ? (top ? 4'd0 : d + 4'd1) : d;
    assign dcarry[i+1]    = dcarry[i] & top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tq     <= RST_TIME;
      yq     <= RST_YEAR;
      ystage <= RST_YEAR;
    end else begin
      if (year_wr) ystage <= year_wdata;
      if (time_wr) begin
        tq <= {2'b00, time_wdata[29:0]};
        yq <= ystage;
      end else if (tick) begin
        tq <= {2'b00, n_mo, n_md, n_wd, n_hr, n_min, n_sec};
        yq <= n_yr;
      end
    end
  end

  assign time_word = tq;
  assign year_word = yq;
  assign alarm     = (tq == match_time) && (yq == match_year);

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !time_wr) |=> ($stable(time_word) && $stable(year_word)));

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !time_wr && time_word[5:0] < 6'd59) |=> (time_word[5:0] == $past(time_word[5:0]) + 6'd1));

  assert_load_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (time_word == {2'b00, $past(time_wdata[29:0])}));

  assert_year_only_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !time_wr && !c_yr) |=> $stable(year_word));

  assert_wday_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !time_wr && c_day && time_word[19:17] == 3'd7) |=> (time_word[19:17] == 3'd1));

  assert_top_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    time_word[31:30] == 2'b00);
endmodule

// File: tb/cal_word_counter_tb.sv
`timescale 1ns/1ps
module cal_word_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        year_wr = 1'b0;
  logic [15:0] year_wdata = '0;
  logic        time_wr = 1'b0;
  logic [31:0] time_wdata = '0;
  logic [31:0] match_time = '1;
  logic [15:0] match_year = '1;
  logic [31:0] time_word;
  logic [15:0] year_word;
  logic        alarm;

  int vectors = 0;
  int errors  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_word_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .year_wr(year_wr), .year_wdata(year_wdata),
    .time_wr(time_wr), .time_wdata(time_wdata),
    .match_time(match_time), .match_year(match_year),
    .time_word(time_word), .year_word(year_word), .alarm(alarm)
  );

  int my, mmo, mmd, mwd, mh, mmi, ms;

  function automatic bit is_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int mdays(int y, int m);
    if (m == 2) return is_leap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [15:0] to_bcd(int y);
    return {4'(y / 1000), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
  endfunction

  function automatic logic [31:0] pack(int mo, int md, int wd, int h, int mi, int s);
    return {2'b00, 5'(mo), 5'(md), 3'(wd), 5'(h), 6'(mi), 6'(s)};
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin ms = 0; mmi++; end
    if (mmi == 60) begin mmi = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mwd = (mwd == 7) ? 1 : mwd + 1;
      mmd++;
      if (mmd > mdays(my, mmo)) begin
        mmd = 1; mmo++;
        if (mmo == 13) begin mmo = 1; my = (my + 1) % 10000; end
      end
    end
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_model(string req);
    check(req, {time_word, 16'h0, year_word},
          {pack(mmo, mmd, mwd, mh, mmi, ms), 16'h0, to_bcd(my)});
  endtask

  task automatic set_model(int y, int mo, int md, int wd, int h, int mi, int s);
    my = y; mmo = mo; mmd = md; mwd = wd; mh = h; mmi = mi; ms = s;
  endtask

  task automatic load(int y, int mo, int md, int wd, int h, int mi, int s);
    @(negedge clk);
    year_wr = 1'b1; year_wdata = to_bcd(y);
    @(negedge clk);
    year_wr = 1'b0; time_wr = 1'b1; time_wdata = pack(mo, md, wd, h, mi, s);
    @(negedge clk);
    time_wr = 1'b0;
    set_model(y, mo, md, wd, h, mi, s);
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    model_step();
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int years[9] = '{2000, 1900, 2100, 2400, 2023, 2024, 1999, 9999, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset time", {32'h0, time_word}, {32'h0, 32'h021E_0000});
    check("R1 reset year", {48'h0, year_word}, {48'h0, 16'h2000});

    // R4: idle cycles leave both words alone
    repeat (5) @(negedge clk);
    check("R4 idle hold", {time_word, 16'h0, year_word}, {32'h021E_0000, 16'h0, 16'h2000});

    // R3 R5 R6 R7: one full leap day, checked every second
    load(2000, 2, 28, 2, 0, 0, 0);
    check_model("R2 load");
    tick = 1'b1;
    for (int n = 0; n < 86400; n++) begin
      @(negedge clk);
      model_step();
      check_model("R3 second sweep");
    end
    tick = 1'b0;
    check("R6 leap Feb 29", {32'h0, time_word}, {32'h0, pack(2, 29, 3, 0, 0, 0)});

    // R5 R6 R7 R8: last second of every month across chosen years
    for (int yi = 0; yi < 9; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        load(years[yi], m, mdays(years[yi], m), ((m + yi) % 7) + 1, 23, 59, 59);
        tick1();
        check_model("R5 month end");
      end
    end
    load(2100, 2, 28, 7, 23, 59, 59);
    tick1();
    check("R6 non-leap century", {32'h0, time_word}, {32'h0, pack(3, 1, 1, 0, 0, 0)});
    load(9999, 12, 31, 5, 23, 59, 59);
    tick1();
    check("R8 year wrap", {48'h0, year_word}, {48'h0, 16'h0000});
    check("R7 weekday", {61'h0, time_word[19:17]}, {61'h0, 3'd6});
    load(1999, 12, 31, 6, 23, 59, 59);
    tick1();
    check("R8 century carry", {48'h0, year_word}, {48'h0, 16'h2000});

    // R9: staged year does not show until the time write
    load(2024, 3, 10, 1, 12, 0, 0);
    @(negedge clk);
    year_wr = 1'b1; year_wdata = 16'h1234;
    @(negedge clk);
    year_wr = 1'b0;
    check_model("R9 year staged only");
    time_wr = 1'b1; time_wdata = 32'hC000_0000 | pack(6, 15, 4, 8, 30, 45);
    @(negedge clk);
    time_wr = 1'b0;
    check("R9 commit both", {time_word, 16'h0, year_word},
          {pack(6, 15, 4, 8, 30, 45), 16'h0, 16'h1234});

    // R10: load beats a simultaneous tick
    time_wr = 1'b1; tick = 1'b1; time_wdata = pack(7, 4, 5, 1, 2, 3);
    @(negedge clk);
    time_wr = 1'b0; tick = 1'b0;
    check("R10 load priority", {time_word, 16'h0, year_word},
          {pack(7, 4, 5, 1, 2, 3), 16'h0, 16'h1234});

    // R11: alarm follows the equality of both words
    load(2024, 3, 10, 1, 12, 0, 0);
    match_time = pack(3, 10, 1, 12, 0, 1);
    match_year = to_bcd(2024);
    #1;
    check("R11 alarm before", {63'h0, alarm}, 64'h0);
    tick1();
    check("R11 alarm on match", {63'h0, alarm}, 64'h1);
    tick1();
    check("R11 alarm after", {63'h0, alarm}, 64'h0);
    match_time = pack(3, 10, 1, 12, 0, 2);
    match_year = to_bcd(2025);
    #1;
    check("R11 year mismatch", {63'h0, alarm}, 64'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule